// File: doc/BRIEF.md
# Two-Level Interrupt Aggregator with Wrap Timer

This block collects single-cycle event pulses into a sticky status register and masks them with a matching enable register. It drives one registered, active-high, level-style interrupt request. The first NUM_EV status bits belong to plain event sources: transmit/receive FIFO level, full, overflow, underrun and dropped-frame conditions, a receive watchdog timeout and receiver/transmitter errors. Power-management events take a longer path. They are latched in a second-level register, masked there, and only then ORed into one read-only summary bit of the top status word.

A 16-bit down-counter divided by a prescaler is built in. Each time it passes through zero to FFFFh it sets a timer status bit, which joins the same clear-by-writing-one scheme.

Software reaches everything through a simple synchronous register port with byte address, write strobe, write data and combinational read data. Byte addresses: 0x00 top status, 0x04 top enable, 0x08 output configuration, 0x0C power-management control, 0x10 timer configuration, 0x14 timer count (read-only).

Top module: `irq_hub`

## Requirements
- R1: After reset, every readable register reads zero and irq_o is low.
- R2: A pulse on ev_i[i] sets top status bit i (i < NUM_EV). The bit stays set until software clears it.
- R3: Writing 1 to a top status bit clears it, and writing 0 leaves it unchanged. When an event and a clear of the same bit fall in one cycle, the bit stays set.
- R4: irq_o is a register. One cycle after a clock edge, it is high exactly when configuration bit 8 was set and some top status bit was set together with its top enable bit at that edge.
- R5: The power-management register latches pm_ev_i[0] (wake), pm_ev_i[1] (port 1 energy) and pm_ev_i[2] (port 2 energy) into pending bits 0, 1 and 2. These pending bits are cleared by writing 1. Their enables sit at bits 9, 14 and 15 of the same register.
- R6: Top status bit 17 reads 1 exactly when some power-management pending bit and its enable are both set. Top enable bit 17 gates it toward irq_o.
- R7: Writing the top status register has no effect on bit 17 or on the power-management pending bits.
- R8: Writing timer configuration bit 29 as 1 while the timer is stopped loads the count from write-data bits 15:0. While bit 29 stays set, the count decrements once every PRESCALE clock cycles.
- R9: When a decrement step finds the count at 0, the count becomes FFFFh and top status bit 19 is set. Bit 19 is cleared by writing 1, and top enable bit 19 masks it.
- R10: While configuration bit 29 is clear, the count holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| ev_i | input | NUM_EV | Plain event pulses, one per top status bit |
| pm_ev_i | input | 3 | Power-management event pulses: wake, port 1 energy, port 2 energy |
| reg_addr_i | input | 8 | Register byte address |
| reg_we_i | input | 1 | Write strobe |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data for reg_addr_i |
| irq_o | output | 1 | Interrupt request |

## Verification
The bench builds the block with all 13 plain event sources and a PRESCALE of 2. This setting lets it sweep every event bit through set, mask, clear-by-zero, clear-by-one and collision. It also walks all three power-management sources through both enable levels. A prescaler of 2 brings the timer's full reload, wrap and post-wrap sequence within a few dozen cycles. That lets the bench check the count and the interrupt in every cycle for preloads 0 through 4, and it also covers the tick phase of two-cycle steps.

// File: rtl/irq_hub.sv
module irq_hub #(
  parameter int NUM_EV   = 13,
  parameter int PRESCALE = 25
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [NUM_EV-1:0] ev_i,
  input  logic [2:0]        pm_ev_i,
  input  logic [7:0]        reg_addr_i,
  input  logic              reg_we_i,
  input  logic [31:0]       reg_wdata_i,
  output logic [31:0]       reg_rdata_o,
  output logic              irq_o
);

  localparam logic [7:0] A_STS  = 8'h00;
  localparam logic [7:0] A_EN   = 8'h04;
  localparam logic [7:0] A_CFG  = 8'h08;
  localparam logic [7:0] A_PM   = 8'h0C;
  localparam logic [7:0] A_TCFG = 8'h10;
  localparam logic [7:0] A_TCNT = 8'h14;
  localparam int PW = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;
  localparam logic [PW-1:0] PRE_LAST = PW'(PRESCALE - 1);

  logic [NUM_EV-1:0] ev_sts_q, ev_en_q;
  logic              pm_en_top_q, tmr_en_top_q, tmr_sts_q;
  logic              irq_cfg_q;
  logic [2:0]        pm_pend_q, pm_en_q;
  logic              tmr_run_q;
  logic [15:0]       tmr_pre_load_q, tmr_cnt_q;
  logic [PW-1:0]     pre_q;
  logic              irq_q;

  logic wr_sts, wr_en, wr_cfg, wr_pm, wr_tcfg;
  assign wr_sts  = reg_we_i && (reg_addr_i == A_STS);
  assign wr_en   = reg_we_i && (reg_addr_i == A_EN);
  assign wr_cfg  = reg_we_i && (reg_addr_i == A_CFG);
  assign wr_pm   = reg_we_i && (reg_addr_i == A_PM);
  assign wr_tcfg = reg_we_i && (reg_addr_i == A_TCFG);

  logic unused_wd;
  assign unused_wd = ^reg_wdata_i;

  logic pm_sum;
  assign pm_sum = |(pm_pend_q & pm_en_q);

  logic tick, wrap, start;
  assign tick  = tmr_run_q && (pre_q == PRE_LAST);
  assign wrap  = tick && (tmr_cnt_q == 16'h0000);
  assign start = wr_tcfg && reg_wdata_i[29] && !tmr_run_q;

  logic [31:0] sts_w, en_w;
  always_comb begin
    sts_w = '0;
    sts_w[NUM_EV-1:0] = ev_sts_q;
    sts_w[17] = pm_sum;
    sts_w[19] = tmr_sts_q;
    en_w = '0;
    en_w[NUM_EV-1:0] = ev_en_q;
    en_w[17] = pm_en_top_q;
    en_w[19] = tmr_en_top_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ev_sts_q  <= '0;
      tmr_sts_q <= 1'b0;
      pm_pend_q <= '0;
    end else begin
      ev_sts_q  <= (ev_sts_q & ~(wr_sts ? reg_wdata_i[NUM_EV-1:0] : '0)) | ev_i;
      tmr_sts_q <= (tmr_sts_q & ~(wr_sts && reg_wdata_i[19])) | wrap;
      pm_pend_q <= (pm_pend_q & ~(wr_pm ? reg_wdata_i[2:0] : 3'b000)) | pm_ev_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ev_en_q      <= '0;
      pm_en_top_q  <= 1'b0;
      tmr_en_top_q <= 1'b0;
      irq_cfg_q    <= 1'b0;
      pm_en_q      <= '0;
    end else begin
      if (wr_en) begin
        ev_en_q      <= reg_wdata_i[NUM_EV-1:0];
        pm_en_top_q  <= reg_wdata_i[17];
        tmr_en_top_q <= reg_wdata_i[19];
      end
      if (wr_cfg) irq_cfg_q <= reg_wdata_i[8];
      if (wr_pm)  pm_en_q   <= {reg_wdata_i[15], reg_wdata_i[14], reg_wdata_i[9]};
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tmr_run_q      <= 1'b0;
      tmr_pre_load_q <= '0;
      tmr_cnt_q      <= '0;
      pre_q          <= '0;
    end else begin
      if (wr_tcfg) begin
        tmr_run_q      <= reg_wdata_i[29];
        tmr_pre_load_q <= reg_wdata_i[15:0];
      end
      if (!tmr_run_q || tick) pre_q <= '0;
      else                    pre_q <= pre_q + 1'b1;
      if (start)     tmr_cnt_q <= reg_wdata_i[15:0];
      else if (tick) tmr_cnt_q <= tmr_cnt_q - 16'd1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) irq_q <= 1'b0;
    else         irq_q <= irq_cfg_q && |(sts_w & en_w);
  end
  assign irq_o = irq_q;

  always_comb begin
    reg_rdata_o = '0;
    case (reg_addr_i)
      A_STS:  reg_rdata_o = sts_w;
      A_EN:   reg_rdata_o = en_w;
      A_CFG:  reg_rdata_o[8] = irq_cfg_q;
      A_PM:   begin
        reg_rdata_o[2:0] = pm_pend_q;
        reg_rdata_o[9]   = pm_en_q[0];
        reg_rdata_o[14]  = pm_en_q[1];
        reg_rdata_o[15]  = pm_en_q[2];
      end
      A_TCFG: reg_rdata_o = {2'b00, tmr_run_q, 13'd0, tmr_pre_load_q};
      A_TCNT: reg_rdata_o[15:0] = tmr_cnt_q;
      default: reg_rdata_o = '0;
    endcase
  end

  p_sticky_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ev_i != '0) |=> ((ev_sts_q & $past(ev_i)) == $past(ev_i)));

  p_w1c_only_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(reg_we_i && reg_addr_i == A_STS) |=> (($past(ev_sts_q) & ~ev_sts_q) == '0));

  p_irq_gate_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !irq_cfg_q |=> !irq_o);

  p_pm_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pm_sum && !wr_pm) |=> pm_sum);

  p_wrap_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tmr_run_q && tick && tmr_cnt_q == 16'h0000) |=> (tmr_cnt_q == 16'hFFFF && tmr_sts_q));

  p_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tmr_run_q && !wr_tcfg) |=> $stable(tmr_cnt_q));

endmodule

// File: tb/irq_hub_tb.sv
`timescale 1ns/1ps
module irq_hub_tb_top;
  localparam int NEV = 13;
  localparam int PS  = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NEV-1:0] ev = '0;
  logic [2:0] pm_ev = '0;
  logic [7:0] addr = '0;
  logic we = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic irq;
  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  irq_hub #(.NUM_EV(NEV), .PRESCALE(PS)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .ev_i(ev), .pm_ev_i(pm_ev),
    .reg_addr_i(addr), .reg_we_i(we), .reg_wdata_i(wdata),
    .reg_rdata_o(rdata), .irq_o(irq));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cyc();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    addr = a; wdata = d; we = 1'b1;
    cyc();
    we = 1'b0; wdata = '0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    addr = a; #1; d = rdata;
  endtask

  initial begin
    #(8 * 20000);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    int pmb [3];
    pmb[0] = 9; pmb[1] = 14; pmb[2] = 15;
    @(negedge clk); @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    for (int a = 0; a < 6; a++) begin
      rd(8'(a * 4), v); chk("R1 reset register", v, 32'h0);
    end
    chk("R1 reset irq", {31'd0, irq}, 32'd0);

    wr(8'h08, 32'h100);
    for (int i = 0; i < NEV; i++) begin
      ev[i] = 1'b1; cyc(); ev = '0;
      rd(8'h00, v); chk("R2 event latch", v, 32'(1) << i);
      cyc();
      rd(8'h00, v); chk("R2 bit held", v, 32'(1) << i);
      chk("R4 masked irq low", {31'd0, irq}, 32'd0);
      wr(8'h04, 32'(1) << ((i + 1) % NEV)); cyc();
      chk("R4 other enable irq low", {31'd0, irq}, 32'd0);
      wr(8'h04, 32'(1) << i);
      chk("R4 irq latency", {31'd0, irq}, 32'd0);
      cyc();
      chk("R4 irq high", {31'd0, irq}, 32'd1);
      wr(8'h00, ~(32'(1) << i) & 32'h000A_1FFF);
      rd(8'h00, v); chk("R3 write zero ignored", v, 32'(1) << i);
      wr(8'h00, 32'(1) << i);
      rd(8'h00, v); chk("R3 cleared", v, 32'h0);
      chk("R4 irq before drop", {31'd0, irq}, 32'd1);
      cyc();
      chk("R4 irq dropped", {31'd0, irq}, 32'd0);
      // collision: event and clear same cycle
      ev[i] = 1'b1; wr(8'h00, 32'(1) << i); ev = '0;
      rd(8'h00, v); chk("R3 event wins", v, 32'(1) << i);
      wr(8'h00, 32'(1) << i);
      wr(8'h04, 32'h0);
    end

    // config gate
    ev[0] = 1'b1; cyc(); ev = '0;
    wr(8'h04, 32'h1); wr(8'h08, 32'h0); cyc(); cyc();
    chk("R4 global gate off", {31'd0, irq}, 32'd0);
    wr(8'h08, 32'h100); cyc();
    chk("R4 global gate on", {31'd0, irq}, 32'd1);
    wr(8'h00, 32'h1); wr(8'h04, 32'h0); cyc();

    for (int j = 0; j < 3; j++) begin
      pm_ev[j] = 1'b1; cyc(); pm_ev = '0;
      rd(8'h0C, v); chk("R5 pending latched", v, 32'(1) << j);
      rd(8'h00, v); chk("R6 summary masked", v, 32'h0);
      wr(8'h0C, 32'(1) << pmb[j]);
      rd(8'h00, v); chk("R6 summary set", v, 32'h0002_0000);
      rd(8'h0C, v); chk("R5 enable readback", v, (32'(1) << pmb[j]) | (32'(1) << j));
      wr(8'h00, 32'h0002_0000);
      rd(8'h00, v); chk("R7 top write ignored", v, 32'h0002_0000);
      rd(8'h0C, v); chk("R7 pending kept", v, (32'(1) << pmb[j]) | (32'(1) << j));
      wr(8'h04, 32'h0002_0000); cyc();
      chk("R6 pm irq", {31'd0, irq}, 32'd1);
      wr(8'h0C, (32'(1) << pmb[j]) | (32'(1) << j));
      rd(8'h00, v); chk("R5 pending cleared", v, 32'h0);
      cyc();
      chk("R6 pm irq dropped", {31'd0, irq}, 32'd0);
      wr(8'h0C, 32'h0); wr(8'h04, 32'h0);
    end

    // timer sweep
    wr(8'h04, 32'h0008_0000);
    for (int p = 0; p < 5; p++) begin
      wr(8'h10, 32'h2000_0000 | 32'(p));
      for (int k = 0; k < (p + 4) * PS; k++) begin
        int t;
        logic [15:0] ec;
        t = k / PS;
        ec = (t <= p) ? 16'(p - t) : 16'(16'hFFFF - 16'(t - p - 1));
        rd(8'h14, v); chk("R8 R9 count", v, {16'd0, ec});
        rd(8'h00, v); chk("R9 wrap status", v, (k >= (p + 1) * PS) ? 32'h0008_0000 : 32'h0);
        chk("R9 timer irq", {31'd0, irq}, (k >= (p + 1) * PS + 1) ? 32'd1 : 32'd0);
        cyc();
      end
      wr(8'h10, 32'(p));
      rd(8'h14, v);
      begin
        logic [31:0] v2;
        cyc(); cyc(); cyc(); cyc(); cyc();
        rd(8'h14, v2); chk("R10 hold while stopped", v2, v);
      end
      rd(8'h10, v); chk("R8 config readback", v, 32'(p));
      wr(8'h00, 32'h0008_0000);
      rd(8'h00, v); chk("R9 clear", v, 32'h0);
      cyc();
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule